// File: doc/BRIEF.md
# Radix-Selectable Multi-Digit Up/Down Counter

This block is a chain of single-digit counter stages that all run from one system clock. An internal divider makes a one-cycle count tick at a slow rate, about 1 Hz at the default setting. On each tick the chain moves one step up or one step down, as the direction input selects. A mode input chooses decimal digits (0–9) or octal digits (0–7). A digit passes a carry to the next digit when it wraps upward, and a borrow when it wraps downward. With two stages the counter covers 00–99, and with three stages it covers 000–999. The number of stages is a parameter.

Each stage drives its own seven-segment pattern. The segment outputs are active low, so a low output lights a segment on a common-anode display. An asynchronous push-button input first passes through a two-flop synchroniser. It then clears every digit to zero, and this clear wins over any tick. The binary value of each digit is also brought out, and so is the tick.

Top module: `radix_updown_counter`

## Requirements
- R1: In decimal mode (`octal_mode`=0), counting up, each digit steps through 0..9. A digit at 9 wraps to 0 and never holds a value above 9. Digit n sits in `digits_o[4n+3:4n]` as plain binary.
- R2: With `count_down`=1, each tick lowers the count by one. A digit at 0 wraps to the mode's maximum, 9 in decimal or 7 in octal.
- R3: A digit above digit 0 moves only on a tick in which every lower digit is at its wrap value: the maximum when counting up, 0 when counting down. The whole counter wraps from the all-maximum value to zero going up, and from zero to the all-maximum value going down.
- R4: In octal mode (`octal_mode`=1), every digit steps through 0..7, and the carry and the borrow happen at 7 and 0. After any tick in octal mode, no digit holds a value above 7.
- R5: Suppose the mode is switched to octal while a digit holds 8 or 9. On the next tick that digit becomes 0, and it passes no carry on to the next digit.
- R6: `tick_o` is high for exactly one cycle in every TICK_DIV cycles. The digits change on no other cycle unless a clear applies.
- R7: `clear_btn` passes through a two-flop synchroniser. When it is sampled high at a rising edge, all digits read 0 after the third rising edge. While the synchronised clear is high, the digits stay at 0 even on tick cycles.
- R8: Digit n drives `seg_n_o[7n+6:7n]`, with bit 0 = segment a through bit 6 = segment g. A 0 lights a segment. The lit segments are: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 all, 9 abcdfg.
- R9: While `rst_n` is low, every digit is 0, `tick_o` is low, and the divider restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_btn | input | 1 | Raw clear push-button, active high, asynchronous to clk |
| octal_mode | input | 1 | 1 selects octal digits, 0 selects decimal digits |
| count_down | input | 1 | 1 counts down, 0 counts up |
| tick_o | output | 1 | One-cycle count tick from the divider |
| digits_o | output | 4*DIGITS | Binary value of each digit, digit 0 lowest |
| seg_n_o | output | 7*DIGITS | Active-low segments a..g for each digit |

## Verification
Two events can land on the same edge: the synchronised clear and a count tick. The bench holds the button down across several tick periods. At every cycle, ticks included, it checks that the digits read zero, and it then releases the button at a fixed offset from a tick so that counting resumes from zero on a known tick. A radix switch can also land on a tick cycle. The bench changes the mode while the digits read 18 and 89 and checks the next tick against the out-of-range-digit rule, which forces 8 or 9 to zero without a carry.

// File: rtl/radix_updown_counter.sv
module radix_updown_counter #(
  parameter int DIGITS   = 2,
  parameter int TICK_DIV = 50_000_000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear_btn,
  input  logic                  octal_mode,
  input  logic                  count_down,
  output logic                  tick_o,
  output logic [4*DIGITS-1:0]   digits_o,
  output logic [7*DIGITS-1:0]   seg_n_o
);

  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DW-1:0]   div_q;
  logic            tick;
  logic [1:0]      btn_sync;
  logic            clr;
  logic [3:0]      top_val;
  logic [3:0]      dq [DIGITS];
  logic [DIGITS-1:0] at_end;
  logic [DIGITS-1:0] step_en;
  logic            run;

  assign tick    = (div_q == DW'(TICK_DIV - 1));
  assign tick_o  = tick;
  assign clr     = btn_sync[1];
  assign top_val = octal_mode ? 4'd7 : 4'd9;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) btn_sync <= 2'b00;
    else        btn_sync <= {btn_sync[0], clear_btn};
  end

  always_comb begin
    run = tick;
    for (int k = 0; k < DIGITS; k++) begin
      step_en[k] = run;
      run = run & at_end[k];
    end
  end

  function automatic logic [6:0] seg_lit(input logic [3:0] v);
    case (v)
      4'd0:    seg_lit = 7'b0111111;
      4'd1:    seg_lit = 7'b0000110;
      4'd2:    seg_lit = 7'b1011011;
      4'd3:    seg_lit = 7'b1001111;
      4'd4:    seg_lit = 7'b1100110;
      4'd5:    seg_lit = 7'b1101101;
      4'd6:    seg_lit = 7'b1111101;
      4'd7:    seg_lit = 7'b0000111;
      4'd8:    seg_lit = 7'b1111111;
      4'd9:    seg_lit = 7'b1101111;
      default: seg_lit = 7'b0000000;
    endcase
  endfunction

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign at_end[i] = count_down ? (dq[i] == 4'd0) : (dq[i] == top_val);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      dq[i] <= 4'd0;
      else if (clr)                    dq[i] <= 4'd0;
      else if (tick && dq[i] > top_val) dq[i] <= 4'd0;
      else if (step_en[i]) begin
        if (count_down) dq[i] <= at_end[i] ? top_val : dq[i] - 4'd1;
        else            dq[i] <= at_end[i] ? 4'd0    : dq[i] + 4'd1;
      end
    end

    assign digits_o[4*i +: 4] = dq[i];
    assign seg_n_o[7*i +: 7]  = ~seg_lit(dq[i]);

    assert_digit_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      dq[i] <= 4'd9);

    assert_octal_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && octal_mode) |=> dq[i] <= 4'd7);

    assert_hold_between_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(dq[i]));

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> dq[i] == 4'd0);
  end

  if (TICK_DIV > 1) begin : g_tick_chk
    assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
  end

endmodule

// File: tb/sim_radix_updown_counter.sv
module sim_radix_updown_counter;
  localparam int ND  = 2;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n, clear_btn, octal_mode, count_down;
  logic tick_o;
  logic [4*ND-1:0] digits_o;
  logic [7*ND-1:0] seg_n_o;

  int total = 0, fails = 0;
  int val = 0, rdx = 10;
  bit finished = 0;

  always #2.5 clk = ~clk;

  radix_updown_counter #(.DIGITS(ND), .TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .clear_btn(clear_btn), .octal_mode(octal_mode),
    .count_down(count_down), .tick_o(tick_o), .digits_o(digits_o), .seg_n_o(seg_n_o));

  function automatic logic [6:0] seg_exp(input int d);
    case (d)
      0: return ~7'h3F; 1: return ~7'h06; 2: return ~7'h5B; 3: return ~7'h4F;
      4: return ~7'h66; 5: return ~7'h6D; 6: return ~7'h7D; 7: return ~7'h07;
      8: return ~7'h7F; 9: return ~7'h6F; default: return 7'h7F;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    int d0, d1;
    d0 = val % rdx;
    d1 = (val / rdx) % rdx;
    chk(req, int'(digits_o), d1 * 16 + d0);
    chk({req, "/R8"}, int'(seg_n_o), int'({seg_exp(d1), seg_exp(d0)}));
  endtask

  task automatic step(input string req);
    @(negedge clk);
    while (!tick_o) @(negedge clk);
    @(negedge clk);
    if (count_down) val = (val + rdx * rdx - 1) % (rdx * rdx);
    else            val = (val + 1) % (rdx * rdx);
    chk_state(req);
  endtask

  task automatic set_radix(input int r);
    int d0, d1;
    d0 = val % rdx;
    d1 = val / rdx;
    rdx = r;
    octal_mode = (r == 8);
    val = d1 * r + d0;
  endtask

  task automatic do_clear();
    clear_btn = 1'b1;
    @(negedge clk);
    while (!tick_o) @(negedge clk);
    @(negedge clk);
    clear_btn = 1'b0;
    val = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [4*ND-1:0] held;
    rst_n = 1'b0; clear_btn = 1'b0; octal_mode = 1'b0; count_down = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 digits", int'(digits_o), 0);
    chk("R9 tick", int'(tick_o), 0);
    chk("R9 seg R8", int'(seg_n_o), int'({seg_exp(0), seg_exp(0)}));
    rst_n = 1'b1;

    // R6: tick period and hold between ticks
    @(negedge clk);
    while (!tick_o) @(negedge clk);
    cyc = 0;
    @(negedge clk);
    held = digits_o;
    while (!tick_o) begin
      chk("R6 hold", int'(digits_o), int'(held));
      cyc++; @(negedge clk);
    end
    chk("R6 period", cyc + 1, DIV);
    @(negedge clk);
    chk("R6 single-cycle tick", int'(tick_o), 0);
    val = 2; chk_state("R6 after two ticks");

    // R1/R3 decimal up sweep through full wrap
    for (int i = 0; i < 120; i++) step("R1 R3 decimal up");
    // R2/R3 decimal down sweep through 00->99
    count_down = 1'b1;
    for (int i = 0; i < 130; i++) step("R2 R3 decimal down");

    // R4 octal up and down
    count_down = 1'b0;
    do_clear();
    set_radix(8);
    for (int i = 0; i < 70; i++) step("R4 octal up");
    count_down = 1'b1;
    for (int i = 0; i < 75; i++) step("R4 octal down");

    // R7 clear: sync delay and priority over ticks
    count_down = 1'b0;
    set_radix(10);
    do_clear();
    for (int i = 0; i < 5; i++) step("R7 prep");
    @(negedge clk);
    while (!tick_o) @(negedge clk);
    @(negedge clk);
    clear_btn = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R7 sync delay", int'(digits_o), 6);
    @(negedge clk);
    chk("R7 cleared", int'(digits_o), 0);
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      chk("R7 clear over tick", int'(digits_o), 0);
    end
    @(negedge clk);
    while (!tick_o) @(negedge clk);
    @(negedge clk);
    clear_btn = 1'b0;
    val = 0;
    for (int i = 0; i < 3; i++) step("R7 resume");

    // R5 radix switch with out-of-range digits
    for (int i = 0; i < 15; i++) step("R5 prep");
    chk("R5 at 18", int'(digits_o), 8'h18);
    octal_mode = 1'b1;
    @(negedge clk);
    while (!tick_o) @(negedge clk);
    @(negedge clk);
    chk("R5 18 to octal", int'(digits_o), 8'h10);
    rdx = 8; val = 8;
    set_radix(10);
    for (int i = 0; i < 79; i++) step("R5 prep2");
    chk("R5 at 89", int'(digits_o), 8'h89);
    octal_mode = 1'b1;
    @(negedge clk);
    while (!tick_o) @(negedge clk);
    @(negedge clk);
    chk("R5 89 to octal", int'(digits_o), 8'h00);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule